// File: doc/BRIEF.md
# Banked Lane Scratchpad with Conflict Replay

This block is the local scratchpad that the lanes of one SIMD engine share. The memory holds 32-bit words spread over NB banks. Word address `a` lives in bank `a % NB` at row `a / NB`. A request is one vector of NL lanes. Each lane carries an enable, an operation code, a word address and a write argument. The vector enters through a valid/ready handshake.

The block routes each enabled lane to its bank. Lanes that meet in one bank at different addresses are replayed over extra cycles. Reads of one shared address are served to all of those lanes in the same pass. Each bank has an integer atomic unit, and every lane receives the word that its address held just before its own operation.

All results are staged and leave together as one response vector, under a second valid/ready handshake. While a vector is still replaying or its response waits, `req_ready` stays low and new requests wait upstream. A requester may drop or change `req_valid` while it is not accepted. The consumer may hold `rsp_ready` low for any number of cycles.

Top module: `spm_scratchpad`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `busy` is 0 and `rsp_valid` is 0.
- R2: A word address maps to bank `addr[BW-1:0]` and row `addr >> BW` (BW = log2 NB). A vector whose enabled lanes all use distinct banks finishes in one pass: `rsp_valid` rises one cycle after the acceptance edge.
- R3: Lanes that use one bank at different addresses, or that use one bank with any non-read, are served in separate passes, one pass per cycle. `busy` stays high for exactly as many cycles as the busiest bank needs passes, with a minimum of one.
- R4: A read joins the pass of the lower lanes in its bank when every lower pending lane in that bank is a read of the same address. All of those lanes get the word in a single pass.
- R5: In each pass the lowest-numbered pending lane of each bank is served. The memory effect and the returned data equal a sequential execution in ascending lane order.
- R6: Every enabled lane returns on `rsp_data[32*i +: 32]` the value its word held immediately before that lane's operation. This applies to reads, writes and atomics alike.
- R7: The operation codes are 0 read, 1 write, 2 add (wrapping), 3 signed min, 4 signed max, 5 and, 6 or, 7 xor and 8 exchange. For codes 2 to 8 the new word is the operation applied to the old word and the lane argument.
- R8: A lane whose enable bit is 0 leaves memory untouched and returns 0.
- R9: `req_ready` is 0 from the acceptance edge until the response is taken, and requests presented meanwhile are ignored. `busy` is 1 exactly while passes are being replayed.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` is unchanged.
- R11: Codes 9 to 15 behave as reads: the word is not modified and the old value is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request vector present |
| req_ready | output | 1 | Block can accept a vector this cycle |
| req_lane_en | input | NL | Per-lane enable |
| req_op | input | 4*NL | Per-lane operation code, lane i at bits [4i+3:4i] |
| req_addr | input | AW*NL | Per-lane word address, lane i at bits [AW*i +: AW] |
| req_wdata | input | 32*NL | Per-lane write or atomic argument |
| busy | output | 1 | Conflict replay in progress |
| rsp_valid | output | 1 | Response vector present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32*NL | Per-lane pre-operation value, 0 for disabled lanes |

## Verification
The assertions rely on reset being applied before the first request. They also rely on NB and ROWS being powers of two, so that every address on the port names a real word. They make no assumption on `req_valid` or `rsp_ready`, because the design samples the request only at acceptance and holds the response by itself. The stimulus changes inputs only between clock edges. It keeps a vector on the port until the block accepts it, and deliberately toggles `req_valid` with unrelated writes during replay. Addresses in the random phase come from a small pool over few banks, so that conflicts, broadcast groups and atomic chains on one word occur often.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int WORD = 32;

  localparam logic [3:0] OP_READ  = 4'd0;
  localparam logic [3:0] OP_WRITE = 4'd1;
  localparam logic [3:0] OP_ADD   = 4'd2;
  localparam logic [3:0] OP_SMIN  = 4'd3;
  localparam logic [3:0] OP_SMAX  = 4'd4;
  localparam logic [3:0] OP_AND   = 4'd5;
  localparam logic [3:0] OP_OR    = 4'd6;
  localparam logic [3:0] OP_XOR   = 4'd7;
  localparam logic [3:0] OP_SWAP  = 4'd8;

  // reserved codes above OP_SWAP act as plain reads
  function automatic logic op_is_read(input logic [3:0] op);
    return (op == OP_READ) || (op > OP_SWAP);
  endfunction

  function automatic logic [WORD-1:0] op_apply(input logic [3:0] op,
                                               input logic [WORD-1:0] old,
                                               input logic [WORD-1:0] arg);
    logic [WORD-1:0] r;
    case (op)
      OP_WRITE, OP_SWAP: r = arg;
      OP_ADD:  r = old + arg;
      OP_SMIN: r = ($signed(old) < $signed(arg)) ? old : arg;
      OP_SMAX: r = ($signed(old) > $signed(arg)) ? old : arg;
      OP_AND:  r = old & arg;
      OP_OR:   r = old | arg;
      OP_XOR:  r = old ^ arg;
      default: r = old;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/spm_conflict_arb.sv
module spm_conflict_arb #(
  parameter int NL = 16,
  parameter int BW = 5,
  parameter int AW = 9
) (
  input  logic [NL-1:0]    pend,
  input  logic [NL*AW-1:0] addr,
  input  logic [NL-1:0]    is_rd,
  output logic [NL-1:0]    grant
);
  // a lane wins unless a lower pending lane in its bank is not a
  // same-address read partner
  always_comb begin
    for (int i = 0; i < NL; i++) begin
      logic ok;
      ok = pend[i];
      for (int j = 0; j < NL; j++) begin
        if (j < i && pend[j] &&
            addr[j*AW +: BW] == addr[i*AW +: BW] &&
            !(is_rd[i] && is_rd[j] && addr[j*AW +: AW] == addr[i*AW +: AW]))
          ok = 1'b0;
      end
      grant[i] = ok;
    end
  end

  always_comb begin
    // R5
    grant_in_pend_chk: assert ((grant & ~pend) == '0);
    // R5
    lowest_served_chk: assert (pend == '0 || (grant & (pend & (~pend + 1'b1))) != '0);
  end
endmodule

// File: rtl/spm_bank.sv
module spm_bank import spm_pkg::*; #(
  parameter int ROWS = 16,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            en,
  input  logic [3:0]      op,
  input  logic [RW-1:0]   row,
  input  logic [WORD-1:0] arg,
  output logic [WORD-1:0] old
);
  logic [WORD-1:0] mem [ROWS];

  assign old = mem[row];

  always_ff @(posedge clk) begin
    if (en && !op_is_read(op))
      mem[row] <= op_apply(op, mem[row], arg);
  end
endmodule

// File: rtl/spm_scratchpad.sv
module spm_scratchpad import spm_pkg::*; #(
  parameter int NL   = 16,
  parameter int NB   = 32,
  parameter int ROWS = 16,
  localparam int BW  = $clog2(NB),
  localparam int RW  = $clog2(ROWS),
  localparam int AW  = BW + RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NL-1:0]    req_lane_en,
  input  logic [NL*4-1:0]  req_op,
  input  logic [NL*AW-1:0] req_addr,
  input  logic [NL*WORD-1:0] req_wdata,
  output logic             busy,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [NL*WORD-1:0] rsp_data
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_RESP} st_e;

  st_e                st;
  logic [NL-1:0]      pend, en_q, is_rd, grant;
  logic [NL*4-1:0]    op_q;
  logic [NL*AW-1:0]   addr_q;
  logic [NL*WORD-1:0] wd_q, stage;

  logic            bk_en  [NB];
  logic [3:0]      bk_op  [NB];
  logic [RW-1:0]   bk_row [NB];
  logic [WORD-1:0] bk_arg [NB];
  logic [WORD-1:0] bk_old [NB];
  logic [WORD-1:0] lane_old [NL];

  always_comb begin
    for (int i = 0; i < NL; i++) is_rd[i] = op_is_read(op_q[i*4 +: 4]);
  end

  spm_conflict_arb #(.NL(NL), .BW(BW), .AW(AW)) u_arb (
    .pend(pend), .addr(addr_q), .is_rd(is_rd), .grant(grant)
  );

  // address crossbar: lowest granted lane of a bank drives it
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bk_en[b] = 1'b0; bk_op[b] = OP_READ; bk_row[b] = '0; bk_arg[b] = '0;
      for (int i = NL-1; i >= 0; i--) begin
        if (grant[i] && addr_q[i*AW +: BW] == BW'(b)) begin
          bk_en[b]  = (st == S_RUN);
          bk_op[b]  = op_q[i*4 +: 4];
          bk_row[b] = addr_q[i*AW + BW +: RW];
          bk_arg[b] = wd_q[i*WORD +: WORD];
        end
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    spm_bank #(.ROWS(ROWS)) u_bank (
      .clk(clk), .en(bk_en[b]), .op(bk_op[b]), .row(bk_row[b]),
      .arg(bk_arg[b]), .old(bk_old[b])
    );
  end

  // read-data crossbar back to lanes
  always_comb begin
    for (int i = 0; i < NL; i++) lane_old[i] = bk_old[addr_q[i*AW +: BW]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= '0; en_q <= '0; op_q <= '0;
      addr_q <= '0; wd_q <= '0; stage <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          en_q   <= req_lane_en;
          pend   <= req_lane_en;
          op_q   <= req_op;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          stage  <= '0;
          st     <= S_RUN;
        end
        S_RUN: begin
          for (int i = 0; i < NL; i++)
            if (grant[i]) stage[i*WORD +: WORD] <= lane_old[i];
          pend <= pend & ~grant;
          if ((pend & ~grant) == '0) st <= S_RESP;
        end
        default: if (rsp_ready) st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign busy      = (st == S_RUN);
  assign rsp_valid = (st == S_RESP);
  assign rsp_data  = stage;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R3
  pend_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (pend & ~$past(pend)) == '0);
  // R8
  pend_in_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~en_q) == '0);
  // R9
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> $stable(addr_q) && !req_ready);
endmodule

// File: tb/spm_scratchpad_bench.sv
`timescale 1ns/1ps
module spm_scratchpad_bench;
  localparam int NL = 16, NB = 32, ROWS = 16, AW = 9, W = NB * ROWS;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic req_ready, busy, rsp_valid;
  logic [NL-1:0] req_lane_en;
  logic [NL*4-1:0] req_op;
  logic [NL*AW-1:0] req_addr;
  logic [NL*32-1:0] req_wdata, rsp_data;

  logic          b_en [NL];
  logic [3:0]    b_op [NL];
  logic [AW-1:0] b_addr [NL];
  logic [31:0]   b_wd [NL];

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      req_lane_en[i] = b_en[i];
      req_op[i*4 +: 4] = b_op[i];
      req_addr[i*AW +: AW] = b_addr[i];
      req_wdata[i*32 +: 32] = b_wd[i];
    end
  end

  spm_scratchpad u_spm_scratchpad (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lane_en(req_lane_en), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int checks = 0, failures = 0;
  bit done = 0, run_chk = 0;
  string cur_tag = "R1";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] mmem [W];
  bit          mknown [W];
  logic [31:0] x_data [NL];
  bit          x_kn [NL];
  int m_st = 0, m_left = 0;

  function automatic logic [31:0] ref_apply(logic [3:0] op, logic [31:0] o, logic [31:0] a);
    case (op)
      4'd1, 4'd8: return a;
      4'd2: return o + a;
      4'd3: return ($signed(o) < $signed(a)) ? o : a;
      4'd4: return ($signed(o) > $signed(a)) ? o : a;
      4'd5: return o & a;
      4'd6: return o | a;
      4'd7: return o ^ a;
      default: return o;
    endcase
  endfunction

  task automatic model_accept();
    int cnt [NB]; bit started [NB]; bit grd [NB]; int ga [NB]; int p;
    for (int b = 0; b < NB; b++) begin cnt[b] = 0; started[b] = 0; grd[b] = 0; ga[b] = 0; end
    for (int i = 0; i < NL; i++) begin
      if (!b_en[i]) begin x_data[i] = 0; x_kn[i] = 1; end
      else begin
        int a, bk; bit rd;
        a = int'(b_addr[i]); bk = a % NB;
        rd = (b_op[i] == 0) || (b_op[i] > 8);
        if (!(started[bk] && rd && grd[bk] && ga[bk] == a)) cnt[bk]++;
        started[bk] = 1; grd[bk] = rd; ga[bk] = a;
        x_data[i] = mmem[a]; x_kn[i] = mknown[a];
        if (!rd) begin
          mmem[a] = ref_apply(b_op[i], mmem[a], b_wd[i]);
          if (b_op[i] == 1 || b_op[i] == 8) mknown[a] = 1;
        end
      end
    end
    p = 1;
    for (int b = 0; b < NB; b++) if (cnt[b] > p) p = cnt[b];
    m_left = p;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_st = 0;
    else case (m_st)
      0: if (req_valid) begin model_accept(); m_st = 1; end
      1: if (m_left == 1) m_st = 2; else m_left--;
      default: if (rsp_ready) m_st = 0;
    endcase
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run_chk && !done) begin
      chk("R9", "req_ready", {31'd0, req_ready}, {31'd0, m_st == 0});
      chk("R9", "busy", {31'd0, busy}, {31'd0, m_st == 1});
      chk(cur_tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, m_st == 2});
      if (m_st == 2 && rsp_valid)
        for (int i = 0; i < NL; i++)
          if (x_kn[i]) chk(cur_tag, $sformatf("lane%0d data", i), rsp_data[i*32 +: 32], x_data[i]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clear_vec();
    for (int i = 0; i < NL; i++) begin b_en[i] = 0; b_op[i] = 0; b_addr[i] = '0; b_wd[i] = 0; end
  endtask

  task automatic set_lane(int i, logic [3:0] op, int a, logic [31:0] wd);
    b_en[i] = 1; b_op[i] = op; b_addr[i] = AW'(a); b_wd[i] = wd;
  endtask

  task automatic run_vec(int hold = 0);
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    if (hold > 0) begin
      rsp_ready = 0;
      repeat (hold) @(negedge clk);
      rsp_ready = 1;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1; failures++; checks++;
      $display("FAIL watchdog run did not finish");
      summary();
    end
  end

  initial begin
    for (int a = 0; a < W; a++) begin mmem[a] = 0; mknown[a] = 0; end
    clear_vec();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "req_ready after release", {31'd0, req_ready}, 32'd1);
    run_chk = 1;

    // fill memory: distinct banks per vector (R2)
    cur_tag = "R2";
    for (int v = 0; v < W / NL; v++) begin
      clear_vec();
      for (int i = 0; i < NL; i++) set_lane(i, 4'd1, v*NL + i, 32'h5A000000 + (v*NL + i) * 32'h101);
      run_vec();
    end
    // R2 conflict-free read of distinct banks
    clear_vec();
    for (int i = 0; i < NL; i++) set_lane(i, 4'd0, i*2 + 64, 0);
    run_vec();

    // R4 broadcast of one address, then split broadcast groups
    cur_tag = "R4";
    clear_vec();
    for (int i = 0; i < NL; i++) set_lane(i, 4'd0, 5, 0);
    run_vec();
    clear_vec();
    for (int i = 0; i < NL; i++) set_lane(i, 4'd0, (i == 8) ? 37 : 5, 0);
    run_vec();

    // R3 all lanes in bank 3 at different rows: 16 passes; R9 junk while busy
    cur_tag = "R3";
    clear_vec();
    for (int i = 0; i < NL; i++) set_lane(i, 4'd0, i*32 + 3, 0);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    clear_vec();
    for (int i = 0; i < NL; i++) set_lane(i, 4'd1, i, 32'hDEAD0000);
    req_valid = 1;
    repeat (5) @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
    cur_tag = "R9";
    clear_vec();
    for (int i = 0; i < NL; i++) set_lane(i, 4'd0, i, 0);
    run_vec();

    // R5/R6 atomic add chain on one word
    cur_tag = "R5";
    clear_vec();
    for (int i = 0; i < 4; i++) set_lane(i, 4'd2, 100, i + 1);
    set_lane(5, 4'd0, 100, 0);
    run_vec();
    cur_tag = "R6";
    clear_vec();
    set_lane(0, 4'd1, 130, 32'h11112222);
    set_lane(1, 4'd0, 130, 0);
    set_lane(2, 4'd8, 130, 32'h33334444);
    set_lane(3, 4'd0, 130, 0);
    run_vec();

    // R7 every atomic code with negative and positive arguments
    cur_tag = "R7";
    for (int r = 0; r < 2; r++) begin
      clear_vec();
      for (int k = 0; k < 7; k++)
        set_lane(k, 4'(k + 2), 200 + k, (r == 0) ? 32'hFFFF_FF00 + k : 32'h0000_7000 + k);
      run_vec();
    end
    clear_vec();
    for (int k = 0; k < 7; k++) set_lane(k, 4'd0, 200 + k, 0);
    run_vec();

    // R8 disabled lanes carry writes that must not land
    cur_tag = "R8";
    clear_vec();
    for (int i = 0; i < NL; i++) begin set_lane(i, 4'd1, 300 + i, 32'hBAD0BAD0); b_en[i] = (i % 2 == 0); end
    run_vec();
    clear_vec();
    for (int i = 0; i < NL; i++) set_lane(i, 4'd0, 300 + i, 0);
    run_vec();

    // R11 reserved codes behave as reads
    cur_tag = "R11";
    clear_vec();
    for (int i = 0; i < 7; i++) set_lane(i, 4'(9 + i), 7 + 32*i, 32'hFACEFACE);
    run_vec();
    clear_vec();
    for (int i = 0; i < 7; i++) set_lane(i, 4'd0, 7 + 32*i, 0);
    run_vec();

    // R10 response held under back-pressure
    cur_tag = "R10";
    clear_vec();
    for (int i = 0; i < NL; i++) set_lane(i, 4'd2, i*32 + 9, 1);
    run_vec(6);

    // mixed random traffic over a few banks
    cur_tag = "R5";
    for (int v = 0; v < 300; v++) begin
      clear_vec();
      for (int i = 0; i < NL; i++) begin
        set_lane(i, 4'($urandom % 10), int'($urandom % 4) * 32 + int'($urandom % 3), $urandom);
        b_en[i] = ($urandom % 4) != 0;
      end
      run_vec(int'($urandom % 3));
    end

    repeat (3) @(negedge clk);
    if (!done) begin done = 1; summary(); end
  end
endmodule